// File: doc/BRIEF.md
# Character-Cell Video Display Controller

This block drives a raster display that shows a grid of text cells. A free-running counter pair walks a frame of 800 pixel clocks by 450 lines at a 25 MHz pixel clock. Inside that frame, 640 × 400 pixels are active and the rest is blanking with active-low sync pulses. Each active pixel belongs to one cell of an 80 × 25 grid of 8 × 16 pixel cells. For each cell the controller reads a character byte and an attribute byte from an internal 2048-entry display buffer. It then turns the character into a row of eight pixels, either through a computed glyph generator or, in graphics mode, by showing the character byte's bits directly. The attribute picks the foreground and background colours and can make the foreground blink.

The display buffer is a simple dual-port store. A host writes a character and attribute pair into one location per clock through a plain write strobe. That port has no back-pressure: every strobed write is taken in the cycle it is presented. A separate strobe loads a row offset that is reduced modulo the row count. The offset selects which buffer row is shown on the top cell row, so the host can scroll without moving data.

The pixel path is a three-register pipeline. The sync outputs pass through the same registers, so colour and sync always describe the same raster position.

Top module: `txv_text_display`

## Requirements
- R1: While `rst_n` is low, `red`, `green` and `blue` are 0 and `hsync_n` and `vsync_n` are 1.
- R2: A line is H_TOTAL = COLS·8 + H_FP + H_SYNC + H_BP clocks (800 by default). Taking clock 0 as the first active pixel of the line, `hsync_n` is low for clocks COLS·8+H_FP up to, but not including, COLS·8+H_FP+H_SYNC.
- R3: A frame is V_TOTAL = ROWS·CELL_H + V_FP + V_SYNC + V_BP lines (450 by default). `vsync_n` is low for whole lines ROWS·CELL_H+V_FP up to, but not including, ROWS·CELL_H+V_FP+V_SYNC, and it changes at the first clock of a line.
- R4: Outside the active area (clocks 0 to COLS·8−1 of lines 0 to ROWS·CELL_H−1), `red`, `green` and `blue` are 0.
- R5: The active pixel at clock h of line v lies in cell column h/8, cell row v/CELL_H and glyph line v mod CELL_H. It shows buffer address ((cell row + offset) mod ROWS)·COLS + column. Pattern bit 7 is the leftmost pixel of the cell. A strobed write (`buf_we`) stores `buf_char` and `buf_attr` at `buf_addr`.
- R6: With attribute bit 7 clear, the pixel pattern is the character byte XOR ((glyph line × 0x11) mod 256).
- R7: With attribute bit 7 set (graphics), the pixel pattern is the character byte itself.
- R8: Attribute bits 2:0 are the foreground colour and bits 5:3 are the background colour. Colour bit 2 drives `red`, bit 1 `green` and bit 0 `blue`. A pattern bit of 1 shows the foreground; a pattern bit of 0 shows the background.
- R9: A frame counter starts at 0 at reset and steps at the end of each frame. When attribute bit 6 is set and bit FLASH_LOG2 of that counter is 1, the foreground is replaced by the background. By default this gives alternating spans of 32 frames.
- R10: An `off_we` strobe loads `off_wdata` mod ROWS as the row offset. A written value of ROWS or more wraps and never shifts the column addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_we | input | 1 | Display buffer write strobe |
| buf_addr | input | clog2(BUF_DEPTH) | Display buffer write address |
| buf_char | input | 8 | Character byte to store |
| buf_attr | input | 8 | Attribute byte to store |
| off_we | input | 1 | Row offset write strobe |
| off_wdata | input | clog2(ROWS) | Row offset value |
| red | output | 1 | Red pixel output |
| green | output | 1 | Green pixel output |
| blue | output | 1 | Blue pixel output |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The hardest behaviour to reach from the ports is the blink phase. With default parameters it needs more than 32 full 360,000-clock frames before the foreground first disappears. The bench therefore builds a small configuration: 4 × 3 cells, two-line glyphs, a 40 × 9 frame and a blink span of 2 frames. It then compares every pixel of four consecutive frames per buffer load, so both blink phases appear under every attribute mix. Offsets 0 to 3 are written across the loads, and the value 3 exercises the modulo wrap of the offset register.

// File: rtl/txv_pkg.sv
package txv_pkg;

  localparam int GLYPH_W = 8;

  typedef struct packed {
    logic       gfx;
    logic       blink;
    logic [2:0] back;
    logic [2:0] fore;
  } txv_attr_t;

endpackage

// File: rtl/txv_timing.sv
module txv_timing #(
  parameter int H_ACTIVE   = 640,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_ACTIVE   = 400,
  parameter int V_FP       = 12,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 36,
  parameter int HW         = 10,
  parameter int VW         = 9,
  parameter int FLASH_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          visible,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blink_phase
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_ON  = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_OFF = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_ON  = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_OFF = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic                line_end;
  logic                frame_end;
  logic [FLASH_LOG2:0] frame_cnt;

  assign line_end  = (hcnt == H_LAST);
  assign frame_end = line_end && (vcnt == V_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt      <= '0;
      vcnt      <= '0;
      frame_cnt <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + HW'(1);
      if (line_end) vcnt <= (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
      if (frame_end) frame_cnt <= frame_cnt + 1'b1;
    end
  end

  assign visible     = (hcnt < H_VIS) && (vcnt < V_VIS);
  assign hsync_n     = !((hcnt >= HS_ON) && (hcnt < HS_OFF));
  assign vsync_n     = !((vcnt >= VS_ON) && (vcnt < VS_OFF));
  assign blink_phase = frame_cnt[FLASH_LOG2];

  // R2
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0));

  // R3
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcnt));

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(frame_cnt));

endmodule

// File: rtl/txv_fetch.sv
module txv_fetch
  import txv_pkg::*;
#(
  parameter int COLS      = 80,
  parameter int ROWS      = 25,
  parameter int CELL_H    = 16,
  parameter int BUF_DEPTH = 2048,
  parameter int HW        = 10,
  parameter int VW        = 9,
  parameter int AW        = 11,
  parameter int ROWW      = 5,
  parameter int COLW      = 7,
  parameter int LW        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            buf_we,
  input  logic [AW-1:0]   buf_addr,
  input  logic [7:0]      buf_char,
  input  logic [7:0]      buf_attr,
  input  logic [HW-1:0]   hcnt,
  input  logic [VW-1:0]   vcnt,
  input  logic            visible,
  input  logic [ROWW-1:0] row_off,
  output logic [7:0]      cell_char,
  output txv_attr_t       cell_attr,
  output logic [LW-1:0]   cell_line
);

  localparam int CELLS = ROWS * COLS;
  localparam logic [ROWW:0] ROWS_X = (ROWW + 1)'(ROWS);

  logic [15:0]     store [BUF_DEPTH];
  logic [15:0]     rd_word;
  logic [VW-1:0]   crow_raw;
  logic [LW-1:0]   line_raw;
  logic [COLW-1:0] col;
  logic [ROWW-1:0] crow;
  logic [ROWW:0]   rsum;
  logic [ROWW-1:0] arow;
  logic [AW-1:0]   rd_addr;

  generate
    if ((CELL_H & (CELL_H - 1)) == 0) begin : g_pow2_rows
      assign crow_raw = vcnt >> LW;
      assign line_raw = vcnt[LW-1:0];
    end else begin : g_div_rows
      assign crow_raw = vcnt / VW'(CELL_H);
      assign line_raw = LW'(vcnt % VW'(CELL_H));
    end
  endgenerate

  always_comb begin
    col     = COLW'(hcnt >> $clog2(GLYPH_W));
    crow    = ROWW'(crow_raw);
    rsum    = {1'b0, crow} + {1'b0, row_off};
    arow    = (rsum >= ROWS_X) ? ROWW'(rsum - ROWS_X) : ROWW'(rsum);
    rd_addr = visible ? (AW'(arow) * AW'(COLS) + AW'(col)) : '0;
  end

  always_ff @(posedge clk) begin
    if (buf_we) store[buf_addr] <= {buf_attr, buf_char};
    rd_word <= store[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_line <= '0;
    else        cell_line <= line_raw;
  end

  assign cell_char = rd_word[7:0];
  assign cell_attr = txv_attr_t'(rd_word[15:8]);

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    visible |-> ({1'b0, rd_addr} < (AW + 1)'(CELLS)));

endmodule

// File: rtl/txv_chargen.sv
module txv_chargen
  import txv_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic [7:0]         code,
  input  logic [LW-1:0]      line,
  input  logic               gfx,
  output logic [GLYPH_W-1:0] pattern
);

  logic [7:0] shade;

  always_comb begin
    shade   = 8'(8'(line) * 8'h11);
    pattern = gfx ? code : (code ^ shade);
  end

endmodule

// File: rtl/txv_pixel.sv
module txv_pixel
  import txv_pkg::*;
#(
  parameter int PXW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GLYPH_W-1:0] pattern,
  input  logic [2:0]         fore,
  input  logic [2:0]         back,
  input  logic               blink,
  input  logic [PXW-1:0]     px,
  input  logic               visible,
  input  logic               hs_n,
  input  logic               vs_n,
  input  logic               blink_phase,
  output logic               red,
  output logic               green,
  output logic               blue,
  output logic               hsync_n,
  output logic               vsync_n
);

  logic [GLYPH_W-1:0] pat_q;
  logic [2:0]         fore_q, back_q, fore_eff, colour, rgb_q;
  logic               blink_q, ph_q, vis_q, hs_q, vs_q, lit;
  logic [PXW-1:0]     px_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q   <= '0;
      fore_q  <= '0;
      back_q  <= '0;
      blink_q <= 1'b0;
      ph_q    <= 1'b0;
      px_q    <= '0;
      vis_q   <= 1'b0;
      hs_q    <= 1'b1;
      vs_q    <= 1'b1;
    end else begin
      pat_q   <= pattern;
      fore_q  <= fore;
      back_q  <= back;
      blink_q <= blink;
      ph_q    <= blink_phase;
      px_q    <= px;
      vis_q   <= visible;
      hs_q    <= hs_n;
      vs_q    <= vs_n;
    end
  end

  always_comb begin
    fore_eff = (blink_q && ph_q) ? back_q : fore_q;
    lit      = pat_q[PXW'(GLYPH_W - 1) - px_q];
    colour   = !vis_q ? 3'b000 : (lit ? fore_eff : back_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q   <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      rgb_q   <= colour;
      hsync_n <= hs_q;
      vsync_n <= vs_q;
    end
  end

  assign red   = rgb_q[2];
  assign green = rgb_q[1];
  assign blue  = rgb_q[0];

endmodule

// File: rtl/txv_text_display.sv
module txv_text_display
  import txv_pkg::*;
#(
  parameter int COLS       = 80,
  parameter int ROWS       = 25,
  parameter int CELL_H     = 16,
  parameter int BUF_DEPTH  = 2048,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_FP       = 12,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 36,
  parameter int FLASH_LOG2 = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_DEPTH)-1:0] buf_addr,
  input  logic [7:0]                   buf_char,
  input  logic [7:0]                   buf_attr,
  input  logic                         off_we,
  input  logic [$clog2(ROWS)-1:0]      off_wdata,
  output logic                         red,
  output logic                         green,
  output logic                         blue,
  output logic                         hsync_n,
  output logic                         vsync_n
);

  localparam int H_ACTIVE = COLS * GLYPH_W;
  localparam int V_ACTIVE = ROWS * CELL_H;
  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW       = $clog2(H_TOTAL);
  localparam int VW       = $clog2(V_TOTAL);
  localparam int AW       = $clog2(BUF_DEPTH);
  localparam int ROWW     = $clog2(ROWS);
  localparam int COLW     = $clog2(COLS);
  localparam int LW       = $clog2(CELL_H);
  localparam int PXW      = $clog2(GLYPH_W);

  logic [HW-1:0]      hcnt;
  logic [VW-1:0]      vcnt;
  logic               vis0, hs0, vs0, phase;
  logic [ROWW-1:0]    off_q;
  logic [7:0]         cell_char;
  txv_attr_t          cell_attr;
  logic [LW-1:0]      cell_line;
  logic [GLYPH_W-1:0] pattern;
  logic [PXW-1:0]     px1;
  logic               vis1, hs1, vs1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_we) off_q <= ROWW'({1'b0, off_wdata} % (ROWW + 1)'(ROWS));
  end

  // R10
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_we |=> ({1'b0, off_q} < (ROWW + 1)'(ROWS)));

  txv_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW), .FLASH_LOG2(FLASH_LOG2)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .visible(vis0),
    .hsync_n(hs0), .vsync_n(vs0), .blink_phase(phase)
  );

  txv_fetch #(
    .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .BUF_DEPTH(BUF_DEPTH),
    .HW(HW), .VW(VW), .AW(AW), .ROWW(ROWW), .COLW(COLW), .LW(LW)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_char(buf_char), .buf_attr(buf_attr), .hcnt(hcnt), .vcnt(vcnt),
    .visible(vis0), .row_off(off_q), .cell_char(cell_char),
    .cell_attr(cell_attr), .cell_line(cell_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px1  <= '0;
      vis1 <= 1'b0;
      hs1  <= 1'b1;
      vs1  <= 1'b1;
    end else begin
      px1  <= hcnt[PXW-1:0];
      vis1 <= vis0;
      hs1  <= hs0;
      vs1  <= vs0;
    end
  end

  txv_chargen #(.LW(LW)) u_chargen (
    .code(cell_char), .line(cell_line), .gfx(cell_attr.gfx), .pattern(pattern)
  );

  txv_pixel #(.PXW(PXW)) u_pixel (
    .clk(clk), .rst_n(rst_n), .pattern(pattern), .fore(cell_attr.fore),
    .back(cell_attr.back), .blink(cell_attr.blink), .px(px1), .visible(vis1),
    .hs_n(hs1), .vs_n(vs1), .blink_phase(phase), .red(red), .green(green),
    .blue(blue), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

endmodule

// File: tb/test_txv_text_display.sv
`timescale 1ns/1ps
module test_txv_text_display;

  localparam int COLS = 4, ROWS = 3, CELL_H = 2, DEPTH = 16;
  localparam int HFP = 2, HSY = 3, HBP = 3, VFP = 1, VSY = 1, VBP = 1, FL = 1;
  localparam int HA = COLS * 8, VA = ROWS * CELL_H;
  localparam int HT = HA + HFP + HSY + HBP, VT = VA + VFP + VSY + VBP;
  localparam int AW = $clog2(DEPTH), OW = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0]    buf_char = '0, buf_attr = '0;
  logic          off_we = 1'b0;
  logic [OW-1:0] off_wdata = '0;
  logic          red, green, blue, hsync_n, vsync_n;

  always #2.5 clk = ~clk;

  txv_text_display #(
    .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .BUF_DEPTH(DEPTH),
    .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP),
    .FLASH_LOG2(FL)
  ) i_txv_text_display (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_char(buf_char), .buf_attr(buf_attr), .off_we(off_we),
    .off_wdata(off_wdata), .red(red), .green(green), .blue(blue),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  int errors = 0, checks = 0;
  int bh = 0, bv = 0, bf = 0;
  int moff = 0, raw_off = 0;
  logic [7:0] mch [DEPTH];
  logic [7:0] mat [DEPTH];

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at h=%0d v=%0d frame=%0d: actual=%0d expected=%0d",
               tag, what, bh, bv, bf, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bh++;
    if (bh == HT) begin
      bh = 0;
      bv++;
      if (bv == VT) begin
        bv = 0;
        bf++;
      end
    end
  endtask

  task automatic check_pos();
    int exp_hs, exp_vs, exp_rgb;
    string tag;
    exp_hs = (bh >= HA + HFP && bh < HA + HFP + HSY) ? 0 : 1;
    exp_vs = (bv >= VA + VFP && bv < VA + VFP + VSY) ? 0 : 1;
    expect_eq("R2", "hsync_n", int'(hsync_n), exp_hs);
    expect_eq("R3", "vsync_n", int'(vsync_n), exp_vs);
    if (bh < HA && bv < VA) begin
      int col, px, crow, line, arow, addr, pat, fg, bg, lit;
      col  = bh / 8;
      px   = bh % 8;
      crow = bv / CELL_H;
      line = bv % CELL_H;
      // R5 and R10: wrapped row plus column addressing
      arow = (crow + moff) % ROWS;
      addr = arow * COLS + col;
      if (mat[addr][7]) begin
        pat = int'(mch[addr]);
        tag = "R7";
      end else begin
        pat = int'(mch[addr]) ^ ((line * 17) & 255);
        tag = "R6";
      end
      // R8: foreground bits 2:0, background bits 5:3
      fg = int'(mat[addr]) & 7;
      bg = (int'(mat[addr]) >> 3) & 7;
      if (mat[addr][6] && (((bf >> FL) & 1) == 1)) begin
        fg  = bg;
        tag = {tag, " R9"};
      end
      lit     = (pat >> (7 - px)) & 1;
      exp_rgb = (lit == 1) ? fg : bg;
      tag     = {tag, " R5 R8"};
      if (raw_off != 0) tag = {tag, " R10"};
    end else begin
      exp_rgb = 0;
      tag     = "R4";
    end
    expect_eq(tag, "rgb", int'({red, green, blue}), exp_rgb);
  endtask

  task automatic load(int s);
    for (int a = 0; a < ROWS * COLS; a++) begin
      buf_we   = 1'b1;
      buf_addr = AW'(a);
      buf_char = 8'(a * 37 + s * 91 + 5);
      buf_attr = 8'(a * 53 + s * 29 + 3);
      mch[a]   = buf_char;
      mat[a]   = buf_attr;
      tick();
    end
    buf_we    = 1'b0;
    off_we    = 1'b1;
    off_wdata = OW'(s);
    tick();
    off_we  = 1'b0;
    raw_off = s;
    moff    = s % ROWS;
  endtask

  initial begin
    logic prev;
    repeat (5) @(negedge clk);
    // R1: reset state
    expect_eq("R1", "rgb", int'({red, green, blue}), 0);
    expect_eq("R1", "hsync_n", int'(hsync_n), 1);
    expect_eq("R1", "vsync_n", int'(vsync_n), 1);
    rst_n = 1'b1;
    do begin
      prev = vsync_n;
      @(negedge clk);
    end while (!(prev && !vsync_n));
    bh = 0;
    bv = VA + VFP;
    bf = 0;
    for (int s = 0; s < 4; s++) begin
      load(s);
      while (bv != VA + VFP) tick();
      while (!(bh == 0 && bv == 0)) tick();
      for (int n = 0; n < 4 * HT * VT; n++) begin
        check_pos();
        tick();
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule